// File: doc/BRIEF.md
# Word-Size-Aware SPI Transmit/Receive FIFO Pair

This block holds the two data queues that sit between a register-side producer/consumer and a serial shift engine. The transmit queue is filled from the register side and drained by the engine; the receive queue is filled by the engine and drained from the register side. Each queue holds 16 entries of up to 32 bits. A configured word size (8, 16, 24 or 32 bits) decides how many low bytes of each pushed word are kept; the upper bytes are stored as zero.

A configuration word carries a receive threshold, a transmit threshold, the word size and two flush bits, one per queue. A flush bit reads back as one for a single cycle and then clears itself; the flush empties only its own queue. A status word reports both fill levels and four sticky fault bits that record a push into a full queue or a pop from an empty one. Two flags compare the levels against the thresholds so that the register side knows when enough receive data has arrived or enough transmit room is free.

Top module: `spi_word_fifo_pair`

## Requirements
- R1: After reset both levels are 0, all fault bits are 0, the configuration word reads 0, and with both thresholds at 0 the receive-ready and transmit-space flags are 1.
- R2: Each queue returns words in the order they were pushed; the head word is presented combinationally on the pop-side data port while the queue is not empty.
- R3: The word size field (configuration bits 9:8) keeps bytes 0..N of each pushed word, where N is the field value (0 = 8 bits, 1 = 16, 2 = 24, 3 = 32); the remaining bytes are stored as zero.
- R4: The status word reports the receive level in bits 12:8 and the transmit level in bits 20:16, each counting 0 to 16 and updated at the clock edge of the push or pop.
- R5: A push into a full queue (level 16) is ignored, the level stays 16, stored data is unchanged, and a sticky overflow bit is set (status bit 0 for transmit, bit 2 for receive).
- R6: A pop from an empty queue is ignored, the level stays 0, and a sticky underflow bit is set (status bit 1 for transmit, bit 3 for receive).
- R7: Writing 1 to configuration bit 11 (receive) or bit 12 (transmit) makes that bit read 1 for exactly one cycle; at the following clock edge the selected queue's level becomes 0 and its two fault bits clear, while the other queue is untouched.
- R8: The receive-ready flag is 1 exactly when the receive level is greater than or equal to the receive threshold (configuration bits 3:0).
- R9: The transmit-space flag is 1 exactly when the transmit level is less than or equal to the transmit threshold (configuration bits 7:4).
- R10: A push and a pop in the same cycle on a non-empty, non-full queue leave the level unchanged and the popped word is the old head.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 13 | Configuration write data |
| cfg_o | output | 13 | Configuration readback |
| status_o | output | 32 | Levels and sticky fault bits |
| tx_push_i | input | 1 | Register-side transmit push |
| tx_wdata_i | input | 32 | Transmit push data |
| tx_pop_i | input | 1 | Engine-side transmit pop |
| tx_rdata_o | output | 32 | Transmit head word |
| tx_empty_o | output | 1 | Transmit queue empty |
| rx_push_i | input | 1 | Engine-side receive push |
| rx_wdata_i | input | 32 | Receive push data |
| rx_pop_i | input | 1 | Register-side receive pop |
| rx_rdata_o | output | 32 | Receive head word |
| rx_full_o | output | 1 | Receive queue full |
| rx_ready_o | output | 1 | Receive level at or above threshold |
| tx_space_o | output | 1 | Transmit level at or below threshold |

## Verification
Both queues are streamed through a scoreboard with full 32-bit words, then with the same pattern word pushed under each of the narrower word sizes, which separates correct byte masking from a shifted or inverted mask. A seventeen-word burst into an empty queue distinguishes a correct full boundary from an off-by-one depth, and a pop on an empty queue does the same at the other end. Flushing one queue while the other holds data tells a per-queue flush from a shared one, and stepping the levels across both thresholds tells the greater-or-equal and less-or-equal comparisons from their strict forms.

// File: rtl/spi_word_fifo_pkg.sv
package spi_word_fifo_pkg;
  localparam int unsigned FIFO_DEPTH = 16;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned LVL_W      = $clog2(FIFO_DEPTH) + 1;
  localparam int unsigned THR_W      = 4;
  localparam int unsigned WS_W       = 2;
  localparam int unsigned CFG_W      = 13;

  // configuration field positions
  localparam int unsigned CFG_RX_THR_LSB = 0;
  localparam int unsigned CFG_TX_THR_LSB = 4;
  localparam int unsigned CFG_WS_LSB     = 8;
  localparam int unsigned CFG_RX_FLUSH   = 11;
  localparam int unsigned CFG_TX_FLUSH   = 12;

  // status field positions
  localparam int unsigned ST_TX_OVF     = 0;
  localparam int unsigned ST_TX_UNF     = 1;
  localparam int unsigned ST_RX_OVF     = 2;
  localparam int unsigned ST_RX_UNF     = 3;
  localparam int unsigned ST_RX_LVL_LSB = 8;
  localparam int unsigned ST_TX_LVL_LSB = 16;

  typedef struct packed {
    logic [THR_W-1:0] rx_thr;
    logic [THR_W-1:0] tx_thr;
    logic [WS_W-1:0]  wsize;
    logic             rx_flush;
    logic             tx_flush;
  } fifo_cfg_t;
endpackage

// File: rtl/spi_word_fifo_cfg.sv
module spi_word_fifo_cfg
  import spi_word_fifo_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output fifo_cfg_t        cfg_o,
  output logic [CFG_W-1:0] rdata_o
);
  fifo_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else begin
      if (we_i) begin
        cfg_q.rx_thr <= wdata_i[CFG_RX_THR_LSB +: THR_W];
        cfg_q.tx_thr <= wdata_i[CFG_TX_THR_LSB +: THR_W];
        cfg_q.wsize  <= wdata_i[CFG_WS_LSB +: WS_W];
      end
      // flush bits live for one cycle only
      cfg_q.rx_flush <= we_i & wdata_i[CFG_RX_FLUSH];
      cfg_q.tx_flush <= we_i & wdata_i[CFG_TX_FLUSH];
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[CFG_RX_THR_LSB +: THR_W] = cfg_q.rx_thr;
    rdata_o[CFG_TX_THR_LSB +: THR_W] = cfg_q.tx_thr;
    rdata_o[CFG_WS_LSB +: WS_W]      = cfg_q.wsize;
    rdata_o[CFG_RX_FLUSH]            = cfg_q.rx_flush;
    rdata_o[CFG_TX_FLUSH]            = cfg_q.tx_flush;
  end

  assign cfg_o = cfg_q;

  logic unused_bit;
  assign unused_bit = wdata_i[10];

  // R7
  rx_flush_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.rx_flush && !(we_i && wdata_i[CFG_RX_FLUSH]) |=> !cfg_q.rx_flush);
  // R7
  tx_flush_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.tx_flush && !(we_i && wdata_i[CFG_TX_FLUSH]) |=> !cfg_q.tx_flush);
endmodule

// File: rtl/spi_word_mask.sv
module spi_word_mask
  import spi_word_fifo_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic [WS_W-1:0] wsize_i,
  input  logic [DW-1:0]   data_i,
  output logic [DW-1:0]   data_o
);
  localparam int unsigned NB = DW / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic keep;
    assign keep = (int'(wsize_i) >= b);
    assign data_o[b*8 +: 8] = keep ? data_i[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/spi_word_fifo_core.sv
module spi_word_fifo_core
  import spi_word_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = FIFO_DEPTH,
  parameter int unsigned DW    = DATA_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic                      push_i,
  input  logic [DW-1:0]             wdata_i,
  input  logic                      pop_i,
  output logic [DW-1:0]             rdata_o,
  output logic [$clog2(DEPTH):0]    level_o,
  output logic                      full_o,
  output logic                      empty_o,
  output logic                      ovf_o,
  output logic                      unf_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned LW = AW + 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] level_q;
  logic          ovf_q, unf_q;
  logic          push_ok, pop_ok;

  assign full_o  = (level_q == LW'(DEPTH));
  assign empty_o = (level_q == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      ovf_q    <= 1'b0;
      unf_q    <= 1'b0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      ovf_q    <= 1'b0;
      unf_q    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
      if (push_i && full_o)  ovf_q <= 1'b1;
      if (pop_i && empty_o)  unf_q <= 1'b1;
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign level_o = level_q;
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;

  // R4
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LW'(DEPTH));
  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !flush_i |=> full_o && ovf_o);
  // R6
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i && !push_i && !flush_i |=> empty_o && unf_o);
  // R7
  flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o && !ovf_o && !unf_o);
  // R10
  push_pop_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_i && !full_o && !empty_o && !flush_i |=> $stable(level_q));
endmodule

// File: rtl/spi_word_fifo_pair.sv
module spi_word_fifo_pair
  import spi_word_fifo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [31:0]       status_o,
  input  logic              tx_push_i,
  input  logic [DATA_W-1:0] tx_wdata_i,
  input  logic              tx_pop_i,
  output logic [DATA_W-1:0] tx_rdata_o,
  output logic              tx_empty_o,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_wdata_i,
  input  logic              rx_pop_i,
  output logic [DATA_W-1:0] rx_rdata_o,
  output logic              rx_full_o,
  output logic              rx_ready_o,
  output logic              tx_space_o
);
  fifo_cfg_t         cfg;
  logic [DATA_W-1:0] tx_wmask, rx_wmask;
  logic [LVL_W-1:0]  tx_lvl, rx_lvl;
  logic              tx_full, rx_empty;
  logic              tx_ovf, tx_unf, rx_ovf, rx_unf;

  spi_word_fifo_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (cfg_o)
  );

  spi_word_mask #(.DW(DATA_W)) u_tx_mask (
    .wsize_i (cfg.wsize),
    .data_i  (tx_wdata_i),
    .data_o  (tx_wmask)
  );

  spi_word_mask #(.DW(DATA_W)) u_rx_mask (
    .wsize_i (cfg.wsize),
    .data_i  (rx_wdata_i),
    .data_o  (rx_wmask)
  );

  spi_word_fifo_core #(.DEPTH(FIFO_DEPTH), .DW(DATA_W)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (cfg.tx_flush),
    .push_i  (tx_push_i),
    .wdata_i (tx_wmask),
    .pop_i   (tx_pop_i),
    .rdata_o (tx_rdata_o),
    .level_o (tx_lvl),
    .full_o  (tx_full),
    .empty_o (tx_empty_o),
    .ovf_o   (tx_ovf),
    .unf_o   (tx_unf)
  );

  spi_word_fifo_core #(.DEPTH(FIFO_DEPTH), .DW(DATA_W)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (cfg.rx_flush),
    .push_i  (rx_push_i),
    .wdata_i (rx_wmask),
    .pop_i   (rx_pop_i),
    .rdata_o (rx_rdata_o),
    .level_o (rx_lvl),
    .full_o  (rx_full_o),
    .empty_o (rx_empty),
    .ovf_o   (rx_ovf),
    .unf_o   (rx_unf)
  );

  always_comb begin
    status_o = '0;
    status_o[ST_TX_OVF] = tx_ovf;
    status_o[ST_TX_UNF] = tx_unf;
    status_o[ST_RX_OVF] = rx_ovf;
    status_o[ST_RX_UNF] = rx_unf;
    status_o[ST_RX_LVL_LSB +: LVL_W] = rx_lvl;
    status_o[ST_TX_LVL_LSB +: LVL_W] = tx_lvl;
  end

  assign rx_ready_o = (rx_lvl >= LVL_W'(cfg.rx_thr));
  assign tx_space_o = (tx_lvl <= LVL_W'(cfg.tx_thr));

  logic unused_full_empty;
  assign unused_full_empty = tx_full ^ rx_empty;

  // R8
  rx_ready_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_ready_o) && $stable(cfg.rx_thr) |-> !rx_empty || cfg.rx_thr == '0);
  // R9
  tx_space_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_space_o) && $stable(cfg.tx_thr) |-> !tx_empty_o);
endmodule

// File: tb/spi_word_fifo_pair_tb.sv
module spi_word_fifo_pair_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [12:0] cfg_wdata_i = '0;
  logic [12:0] cfg_o;
  logic [31:0] status_o;
  logic        tx_push_i = 1'b0, tx_pop_i = 1'b0, rx_push_i = 1'b0, rx_pop_i = 1'b0;
  logic [31:0] tx_wdata_i = '0, rx_wdata_i = '0;
  logic [31:0] tx_rdata_o, rx_rdata_o;
  logic        tx_empty_o, rx_full_o, rx_ready_o, tx_space_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] tx_q[$];
  logic [31:0] rx_q[$];
  logic [1:0]  ws_m = 2'd0;

  always #5 clk_i = ~clk_i;

  spi_word_fifo_pair u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_m(input logic [31:0] d);
    logic [31:0] m = '0;
    for (int b = 0; b <= int'(ws_m); b++) m[b*8 +: 8] = 8'hFF;
    return d & m;
  endfunction

  task automatic cfg_wr(input logic [3:0] rthr, input logic [3:0] tthr,
                        input logic [1:0] ws, input logic rfl, input logic tfl);
    cfg_wdata_i = {tfl, rfl, 1'b0, ws, tthr, rthr};
    cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    ws_m = ws;
  endtask

  // driver: push to DUT and to scoreboard
  task automatic drv_tx(input logic [31:0] d);
    tx_wdata_i = d; tx_push_i = 1'b1;
    if (tx_q.size() < 16) tx_q.push_back(mask_m(d));
    @(negedge clk_i);
    tx_push_i = 1'b0;
  endtask

  task automatic drv_rx(input logic [31:0] d);
    rx_wdata_i = d; rx_push_i = 1'b1;
    if (rx_q.size() < 16) rx_q.push_back(mask_m(d));
    @(negedge clk_i);
    rx_push_i = 1'b0;
  endtask

  // monitor: pop and compare against scoreboard
  task automatic mon_tx(input string req);
    while (tx_q.size() > 0) begin
      chk(req, tx_rdata_o, tx_q.pop_front());
      tx_pop_i = 1'b1;
      @(negedge clk_i);
      tx_pop_i = 1'b0;
    end
  endtask

  task automatic mon_rx(input string req);
    while (rx_q.size() > 0) begin
      chk(req, rx_rdata_o, rx_q.pop_front());
      rx_pop_i = 1'b1;
      @(negedge clk_i);
      rx_pop_i = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 status", status_o, 32'h0);
    chk("R1 cfg", {19'b0, cfg_o}, 32'h0);
    chk("R1 flags", {30'b0, rx_ready_o, tx_space_o}, 32'h3);

    // R2 full width ordering on both queues
    cfg_wr(4'd0, 4'd15, 2'd3, 1'b0, 1'b0);
    drv_tx(32'hDEADBEEF); drv_tx(32'h01234567); drv_tx(32'h89ABCDEF);
    chk("R4 tx level", {27'b0, status_o[20:16]}, 32'd3);
    mon_tx("R2 tx order");
    drv_rx(32'hCAFEF00D); drv_rx(32'h5A5A5A5A);
    chk("R4 rx level", {27'b0, status_o[12:8]}, 32'd2);
    mon_rx("R2 rx order");

    // R3 word size masking
    for (int w = 0; w < 4; w++) begin
      cfg_wr(4'd0, 4'd15, 2'(w), 1'b0, 1'b0);
      drv_tx(32'hA5C31234);
      drv_rx(32'h9876FEDC);
      mon_tx("R3 tx mask");
      mon_rx("R3 rx mask");
    end

    // R5 overflow at 16
    cfg_wr(4'd0, 4'd15, 2'd3, 1'b0, 1'b0);
    for (int i = 0; i < 17; i++) drv_tx(32'h1000 + i);
    chk("R5 tx level full", {27'b0, status_o[20:16]}, 32'd16);
    chk("R5 tx ovf", {31'b0, status_o[0]}, 32'd1);
    mon_tx("R5 tx data kept");
    chk("R4 tx level drained", {27'b0, status_o[20:16]}, 32'd0);
    for (int i = 0; i < 17; i++) drv_rx(32'h2000 + i);
    chk("R5 rx full", {31'b0, rx_full_o}, 32'd1);
    chk("R5 rx ovf", {31'b0, status_o[2]}, 32'd1);
    mon_rx("R5 rx data kept");

    // R6 underflow
    tx_pop_i = 1'b1; @(negedge clk_i); tx_pop_i = 1'b0;
    chk("R6 tx unf", {31'b0, status_o[1]}, 32'd1);
    chk("R6 tx level", {27'b0, status_o[20:16]}, 32'd0);
    rx_pop_i = 1'b1; @(negedge clk_i); rx_pop_i = 1'b0;
    chk("R6 rx unf", {31'b0, status_o[3]}, 32'd1);

    // R7 receive flush leaves transmit untouched
    drv_rx(32'h11); drv_rx(32'h22); drv_rx(32'h33);
    drv_tx(32'h44); drv_tx(32'h55);
    cfg_wr(4'd0, 4'd15, 2'd3, 1'b1, 1'b0);
    chk("R7 rx flush bit", {31'b0, cfg_o[11]}, 32'd1);
    chk("R7 rx level before", {27'b0, status_o[12:8]}, 32'd3);
    @(negedge clk_i);
    chk("R7 rx flush clears", {31'b0, cfg_o[11]}, 32'd0);
    chk("R7 rx level", {27'b0, status_o[12:8]}, 32'd0);
    chk("R7 rx faults", {30'b0, status_o[3:2]}, 32'd0);
    chk("R7 tx untouched", {27'b0, status_o[20:16]}, 32'd2);
    chk("R7 tx faults kept", {30'b0, status_o[1:0]}, 32'd3);
    rx_q.delete();
    cfg_wr(4'd0, 4'd15, 2'd3, 1'b0, 1'b1);
    chk("R7 tx flush bit", {31'b0, cfg_o[12]}, 32'd1);
    @(negedge clk_i);
    chk("R7 tx flushed", {27'b0, status_o[20:16], 2'b0, status_o[1:0]}, 32'd0);
    tx_q.delete();

    // R8 receive threshold
    cfg_wr(4'd4, 4'd2, 2'd3, 1'b0, 1'b0);
    drv_rx(32'h1); drv_rx(32'h2); drv_rx(32'h3);
    chk("R8 below thr", {31'b0, rx_ready_o}, 32'd0);
    drv_rx(32'h4);
    chk("R8 at thr", {31'b0, rx_ready_o}, 32'd1);
    mon_rx("R2 rx after thr");

    // R9 transmit threshold
    drv_tx(32'hA); drv_tx(32'hB);
    chk("R9 at thr", {31'b0, tx_space_o}, 32'd1);
    drv_tx(32'hC);
    chk("R9 above thr", {31'b0, tx_space_o}, 32'd0);

    // R10 simultaneous push and pop
    chk("R10 head", tx_rdata_o, tx_q.pop_front());
    tx_wdata_i = 32'hD; tx_push_i = 1'b1; tx_pop_i = 1'b1;
    tx_q.push_back(32'hD);
    @(negedge clk_i);
    tx_push_i = 1'b0; tx_pop_i = 1'b0;
    chk("R10 level", {27'b0, status_o[20:16]}, 32'd3);
    mon_tx("R10 order");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule